// File: doc/BRIEF.md
# Keyed Oscillator Configuration Register Bank

This block is the software-facing register bank for a configurable oscillator. A 32-bit register bus with address, write enable, write data and combinational read data writes nine word slots. The block turns the stored settings into decoded configuration outputs: oscillator run/stop, pause, a range selector with its active-stage mask, per-stage drive strengths, a post-divider setting and a phase-shift control. The oscillator, clock switching and interrupt logic sit outside it.

Every configuration word carries a key or a coded value. A write that fails its check is not dropped. It loads a defined safe setting for the fields it covers and sets a sticky error flag, which software clears by writing 1 to it. Readback returns the decoded settings re-encoded in their valid form, with key fields reading zero.

Word map by byte offset (address bits [1:0] ignored): 0x00 control, 0x04 drive stages 0-3, 0x08 drive stages 4-7, 0x0C pause, 0x10 divider, 0x14 phase, 0x18 status. 0x1C and 0x20 are reserved. Every unmapped word reads zero and ignores writes.

Top module: `osc_keyreg_bank`

## Requirements
- R1: After reset the outputs and readback are as follows. Oscillator enabled, not paused, range LOW (stage mask 0xFF), all drive fields zero, divisor 16 (ratio 16). Phase output enabled with shift 0 and no inversion. Error flag clear. Control reads 0x00FABFA4, divider reads 0x00000AB0, status reads 0x00000002.
- R2: The enable code is control bits [23:12]. 0xFAB enables and 0xD1E disables; both values are parameters. Any other code enables and counts as a bad write. Readback shows the code of the resulting state.
- R3: The range code is control bits [11:0]. It is valid when bits [11:2] equal 0x3E9, and bits [1:0] then give a Gray selector: 00 LOW, 01 MEDIUM, 11 HIGH, 10 TOOHIGH. These select 8, 6, 4 and 2 active stages, and the stage mask has those lowest bits set. An invalid range code selects LOW and counts as a bad write.
- R4: A drive word takes effect only when bits [31:16] equal 0x9696. It then loads four 3-bit fields from bits [2:0], [6:4], [10:8] and [14:12], for stages 0-3 (offset 0x04) or stages 4-7 (offset 0x08). Any other key zeroes all four fields of that word, leaves the other word untouched and counts as a bad write. On the drive output, stage k occupies bits [3k+2:3k].
- R5: The divider word is valid when bits [11:5] equal 0x55, which means 0xAA0 plus a divisor in bits [4:0]. Divisor 0 gives ratio 32, and 1 to 31 give that ratio. An invalid word sets divisor 31 and counts as a bad write. Readback is 0xAA0 plus the divisor.
- R6: The phase word has its key in bits [7:0]; 0xAA is valid. A valid key loads inversion from bit 8, enable from bit 9 and shift from bits [23:16]. Any other key sets enable 1, shift 0 and inversion 0, and counts as a bad write. Readback puts the same fields at the same positions, with the key reading zero.
- R7: The pause word is a 32-bit code. 0xA5A50002 pauses and 0xA5A50001 wakes. Any other value wakes and counts as a bad write. Readback is the code of the resulting state.
- R8: Status bit 0 is the sticky bad-write flag. A bad write sets it, and valid writes leave it unchanged. Writing 1 to status bit 0 clears it, and writing 0 there has no effect. Status bit 1 mirrors the oscillator enable and bit 2 mirrors pause.
- R9: Writes to reserved or unmapped words change nothing, and reads of them (0x1C, 0x20, 0x24 to 0x3C) return zero.
- R10: A write updates the decoded outputs at the clock edge that samples it, so they are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| osc_en_o | output | 1 | Oscillator run request |
| osc_pause_o | output | 1 | Oscillator pause request |
| range_o | output | 2 | Gray-coded range selector |
| stage_mask_o | output | STAGES | Active delay stages, lowest bits set |
| drive_o | output | STAGES*DS_W | Per-stage drive fields, stage k at bits [3k+2:3k] |
| div_code_o | output | 5 | Stored divisor code |
| div_ratio_o | output | 6 | Effective division ratio (1 to 32) |
| phase_en_o | output | 1 | Phase-shifted output enable |
| phase_flip_o | output | 1 | Phase-shifted output inversion |
| phase_shift_o | output | 8 | Phase shift in input clocks |
| bad_write_o | output | 1 | Sticky bad-write flag |

## Verification
The assertions assume one bus write per cycle. They also assume the address and write data are stable across the sampling edge of a write, and that the strobe is low at every reset release. The bench drives all bus inputs at the falling edge, raises the strobe for exactly one cycle per write and holds it low while reset is applied. This keeps every edge-triggered property tied to a single decoded word. Since a bad write and a status write never target the same word, the flag's set and clear cases are reached in separate cycles, and the bench exercises both.

// File: rtl/osc_key_pkg.sv
package osc_key_pkg;

  localparam int WORD_W   = 32;
  localparam int DIV_W    = 5;
  localparam int SHIFT_W  = 8;
  localparam int FPITCH   = 4;   // bit pitch of drive fields in a bus word

  // word indices (byte offset / 4)
  localparam int W_CTRL  = 0;
  localparam int W_DRVA  = 1;
  localparam int W_DRVB  = 2;
  localparam int W_PAUSE = 3;
  localparam int W_DIV   = 4;
  localparam int W_PHASE = 5;
  localparam int W_STAT  = 6;

  localparam logic [15:0] DRV_KEY    = 16'h9696;
  localparam logic [6:0]  DIV_TAG    = 7'h55;
  localparam logic [7:0]  PHASE_KEY  = 8'hAA;
  localparam logic [9:0]  RANGE_TAG  = 10'h3E9;
  localparam logic [31:0] WAKE_WORD  = 32'hA5A5_0001;
  localparam logic [31:0] PAUSE_WORD = 32'hA5A5_0002;
  localparam logic [DIV_W-1:0] DIV_RESET = 5'd16;
  localparam logic [DIV_W-1:0] DIV_SAFE  = 5'd31;

  typedef enum logic [1:0] {
    RNG_LOW  = 2'b00,
    RNG_MED  = 2'b01,
    RNG_HIGH = 2'b11,
    RNG_TOP  = 2'b10
  } rng_e;

endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/osc_field_check.sv
module osc_field_check
  import osc_key_pkg::*;
#(
  parameter logic [11:0] ENA_CODE = 12'hFAB,
  parameter logic [11:0] DIS_CODE = 12'hD1E,
  parameter int          DS_W     = 3,
  parameter int          PER_WORD = 4
) (
  input  logic [WORD_W-1:0]          wdata_i,
  output logic                       ena_bad_o,
  output logic                       ena_val_o,
  output logic                       rng_bad_o,
  output rng_e                       rng_val_o,
  output logic                       drv_bad_o,
  output logic [PER_WORD*DS_W-1:0]   drv_val_o,
  output logic                       div_bad_o,
  output logic [DIV_W-1:0]           div_val_o,
  output logic                       phs_bad_o,
  output logic                       phs_en_o,
  output logic                       phs_flip_o,
  output logic [SHIFT_W-1:0]         phs_shift_o,
  output logic                       pau_bad_o,
  output logic                       pau_val_o
);
  logic [11:0] ena_code;
  logic        drv_ok;

  // enable code: disable only on the exact disable value
  assign ena_code  = wdata_i[23:12];
  assign ena_bad_o = (ena_code != ENA_CODE) && (ena_code != DIS_CODE);
  assign ena_val_o = (ena_code != DIS_CODE);

  // range code: tag in upper bits, Gray selector below; fall back to slowest
  assign rng_bad_o = (wdata_i[11:2] != RANGE_TAG);
  assign rng_val_o = rng_bad_o ? RNG_LOW : rng_e'(wdata_i[1:0]);

  // drive fields, one generated slice per stage
  assign drv_ok    = (wdata_i[31:16] == DRV_KEY);
  assign drv_bad_o = !drv_ok;
  for (genvar g = 0; g < PER_WORD; g++) begin : g_drv
    assign drv_val_o[g*DS_W +: DS_W] = drv_ok ? wdata_i[g*FPITCH +: DS_W] : '0;
  end

  // divider
  assign div_bad_o = (wdata_i[11:5] != DIV_TAG);
  assign div_val_o = div_bad_o ? DIV_SAFE : wdata_i[DIV_W-1:0];

  // phase
  assign phs_bad_o   = (wdata_i[7:0] != PHASE_KEY);
  assign phs_en_o    = phs_bad_o ? 1'b1 : wdata_i[9];
  assign phs_flip_o  = phs_bad_o ? 1'b0 : wdata_i[8];
  assign phs_shift_o = phs_bad_o ? '0   : wdata_i[16 +: SHIFT_W];

  // pause
  assign pau_bad_o = (wdata_i != WAKE_WORD) && (wdata_i != PAUSE_WORD);
  assign pau_val_o = (wdata_i == PAUSE_WORD);
endmodule

// File: rtl/osc_sticky_flag.sv
module osc_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/osc_keyreg_bank.sv
module osc_keyreg_bank
  import osc_key_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          STAGES   = 8,
  parameter int          DS_W     = 3,
  parameter logic [11:0] ENA_CODE = 12'hFAB,
  parameter logic [11:0] DIS_CODE = 12'hD1E
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     osc_en_o,
  output logic                     osc_pause_o,
  output logic [1:0]               range_o,
  output logic [STAGES-1:0]        stage_mask_o,
  output logic [STAGES*DS_W-1:0]   drive_o,
  output logic [DIV_W-1:0]         div_code_o,
  output logic [DIV_W:0]           div_ratio_o,
  output logic                     phase_en_o,
  output logic                     phase_flip_o,
  output logic [SHIFT_W-1:0]       phase_shift_o,
  output logic                     bad_write_o
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int PER_WORD = STAGES / 2;
  localparam int HALF_W   = PER_WORD * DS_W;
  localparam int CNT_W    = $clog2(STAGES + 1);

  logic             rst_s_n;
  logic [IDX_W-1:0] word_idx;
  logic             unused_addr_lsb;

  assign word_idx        = addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = ^addr_i[1:0];

  osc_rst_sync i_rst_sync (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_s_n));

  // ---- field validation ----
  logic                   c_ena_bad, c_ena, c_rng_bad, c_drv_bad, c_div_bad;
  logic                   c_phs_bad, c_phs_en, c_phs_flip, c_pau_bad, c_pau;
  rng_e                   c_rng;
  logic [HALF_W-1:0]      c_drv;
  logic [DIV_W-1:0]       c_div;
  logic [SHIFT_W-1:0]     c_shift;

  osc_field_check #(
    .ENA_CODE(ENA_CODE), .DIS_CODE(DIS_CODE), .DS_W(DS_W), .PER_WORD(PER_WORD)
  ) i_field_check (
    .wdata_i    (wdata_i),
    .ena_bad_o  (c_ena_bad),  .ena_val_o (c_ena),
    .rng_bad_o  (c_rng_bad),  .rng_val_o (c_rng),
    .drv_bad_o  (c_drv_bad),  .drv_val_o (c_drv),
    .div_bad_o  (c_div_bad),  .div_val_o (c_div),
    .phs_bad_o  (c_phs_bad),  .phs_en_o  (c_phs_en),
    .phs_flip_o (c_phs_flip), .phs_shift_o(c_shift),
    .pau_bad_o  (c_pau_bad),  .pau_val_o (c_pau)
  );

  // ---- configuration state ----
  logic                   ena_d, ena_q, pau_d, pau_q;
  rng_e                   rng_d, rng_q;
  logic [STAGES*DS_W-1:0] drv_d, drv_q;
  logic [DIV_W-1:0]       div_d, div_q;
  logic                   phs_en_d, phs_en_q, phs_flip_d, phs_flip_q;
  logic [SHIFT_W-1:0]     shift_d, shift_q;
  logic                   bad_pulse, clr_req;

  always_comb begin
    ena_d      = ena_q;
    rng_d      = rng_q;
    drv_d      = drv_q;
    div_d      = div_q;
    phs_en_d   = phs_en_q;
    phs_flip_d = phs_flip_q;
    shift_d    = shift_q;
    pau_d      = pau_q;
    bad_pulse  = 1'b0;
    clr_req    = 1'b0;
    if (wr_en_i) begin
      case (word_idx)
        IDX_W'(W_CTRL): begin
          ena_d     = c_ena;
          rng_d     = c_rng;
          bad_pulse = c_ena_bad | c_rng_bad;
        end
        IDX_W'(W_DRVA): begin
          drv_d[0 +: HALF_W] = c_drv;
          bad_pulse          = c_drv_bad;
        end
        IDX_W'(W_DRVB): begin
          drv_d[HALF_W +: HALF_W] = c_drv;
          bad_pulse               = c_drv_bad;
        end
        IDX_W'(W_PAUSE): begin
          pau_d     = c_pau;
          bad_pulse = c_pau_bad;
        end
        IDX_W'(W_DIV): begin
          div_d     = c_div;
          bad_pulse = c_div_bad;
        end
        IDX_W'(W_PHASE): begin
          phs_en_d   = c_phs_en;
          phs_flip_d = c_phs_flip;
          shift_d    = c_shift;
          bad_pulse  = c_phs_bad;
        end
        IDX_W'(W_STAT): clr_req = wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ena_q      <= 1'b1;
      rng_q      <= RNG_LOW;
      drv_q      <= '0;
      div_q      <= DIV_RESET;
      phs_en_q   <= 1'b1;
      phs_flip_q <= 1'b0;
      shift_q    <= '0;
      pau_q      <= 1'b0;
    end else begin
      ena_q      <= ena_d;
      rng_q      <= rng_d;
      drv_q      <= drv_d;
      div_q      <= div_d;
      phs_en_q   <= phs_en_d;
      phs_flip_q <= phs_flip_d;
      shift_q    <= shift_d;
      pau_q      <= pau_d;
    end
  end

  osc_sticky_flag i_bad_flag (
    .clk_i(clk_i), .rst_ni(rst_s_n), .set_i(bad_pulse), .clr_i(clr_req),
    .flag_o(bad_write_o)
  );

  // ---- decoded outputs ----
  logic [CNT_W-1:0] act_cnt;

  always_comb begin
    case (rng_q)
      RNG_MED:  act_cnt = CNT_W'(STAGES - 2);
      RNG_HIGH: act_cnt = CNT_W'(STAGES - 4);
      RNG_TOP:  act_cnt = CNT_W'(STAGES - 6);
      default:  act_cnt = CNT_W'(STAGES);
    endcase
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_mask
    assign stage_mask_o[s] = (CNT_W'(s) < act_cnt);
  end

  assign osc_en_o      = ena_q;
  assign osc_pause_o   = pau_q;
  assign range_o       = rng_q;
  assign drive_o       = drv_q;
  assign div_code_o    = div_q;
  assign div_ratio_o   = (div_q == '0) ? (DIV_W+1)'(32) : {1'b0, div_q};
  assign phase_en_o    = phs_en_q;
  assign phase_flip_o  = phs_flip_q;
  assign phase_shift_o = shift_q;

  // ---- readback ----
  logic [WORD_W-1:0] drv_word_a, drv_word_b;

  always_comb begin
    drv_word_a = '0;
    drv_word_b = '0;
    for (int k = 0; k < PER_WORD; k++) begin
      drv_word_a[k*FPITCH +: DS_W] = drv_q[k*DS_W +: DS_W];
      drv_word_b[k*FPITCH +: DS_W] = drv_q[HALF_W + k*DS_W +: DS_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (word_idx)
      IDX_W'(W_CTRL):  rdata_o = {8'h00, (ena_q ? ENA_CODE : DIS_CODE), RANGE_TAG, rng_q};
      IDX_W'(W_DRVA):  rdata_o = drv_word_a;
      IDX_W'(W_DRVB):  rdata_o = drv_word_b;
      IDX_W'(W_PAUSE): rdata_o = pau_q ? PAUSE_WORD : WAKE_WORD;
      IDX_W'(W_DIV):   rdata_o = {20'h0, DIV_TAG, div_q};
      IDX_W'(W_PHASE): rdata_o = {8'h00, shift_q, 6'h00, phs_en_q, phs_flip_q, 8'h00};
      IDX_W'(W_STAT):  rdata_o = {29'h0, pau_q, ena_q, bad_write_o};
      default:         rdata_o = {WORD_W{unused_addr_lsb & 1'b0}};
    endcase
  end

  // ---- assertions ----
  // R2
  ena_off_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (wr_en_i && word_idx == IDX_W'(W_CTRL) && wdata_i[23:12] == DIS_CODE) |=> !osc_en_o);
  // R3
  stage_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    stage_mask_o[0] && ($countones(stage_mask_o) >= 2) &&
    ((stage_mask_o & (stage_mask_o + 1'b1)) == '0));
  // R4
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !wr_en_i |=> $stable(drive_o));
  // R5
  div_force_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (wr_en_i && word_idx == IDX_W'(W_DIV) && wdata_i[11:5] != DIV_TAG) |=> (div_code_o == DIV_SAFE));
  // R6
  phs_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (wr_en_i && word_idx == IDX_W'(W_PHASE) && wdata_i[7:0] != PHASE_KEY)
      |=> (phase_en_o && phase_shift_o == '0 && !phase_flip_o));
endmodule

// File: tb/test_osc_keyreg_bank.sv
module test_osc_keyreg_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WK = 32'hA5A5_0001;
  localparam logic [31:0] PZ = 32'hA5A5_0002;
  localparam int NV = 15;

  // {req[3:0], waddr[5:0], wdata[31:0], raddr[5:0], expected[31:0]}
  localparam logic [79:0] VEC [NV] = '{
    {4'd2, 6'h00, 32'h00D1EFA5, 6'h00, 32'h00D1EFA5},  // R2/R3 disable, MEDIUM
    {4'd3, 6'h00, 32'h00FABFA7, 6'h00, 32'h00FABFA7},  // R3 HIGH
    {4'd2, 6'h00, 32'h00123FA6, 6'h00, 32'h00FABFA6},  // R2 bad code -> enabled
    {4'd3, 6'h00, 32'h00FAB0A5, 6'h00, 32'h00FABFA4},  // R3 bad range -> LOW
    {4'd4, 6'h04, 32'h96967531, 6'h04, 32'h00007531},  // R4 word A
    {4'd4, 6'h08, 32'h96960246, 6'h08, 32'h00000246},  // R4 word B
    {4'd4, 6'h04, 32'h12347777, 6'h04, 32'h00000000},  // R4 bad key zeroes
    {4'd9, 6'h1C, 32'hFFFFFFFF, 6'h08, 32'h00000246},  // R9 reserved write ignored
    {4'd5, 6'h10, 32'h00000AA3, 6'h10, 32'h00000AA3},  // R5
    {4'd5, 6'h10, 32'h00000AA0, 6'h10, 32'h00000AA0},  // R5 divisor 0
    {4'd5, 6'h10, 32'h00000BB3, 6'h10, 32'h00000ABF},  // R5 bad -> 31
    {4'd6, 6'h14, 32'h002C01AA, 6'h14, 32'h002C0100},  // R6
    {4'd6, 6'h14, 32'h00070355, 6'h14, 32'h00000200},  // R6 bad key
    {4'd7, 6'h0C, PZ,           6'h0C, PZ},            // R7 pause
    {4'd7, 6'h0C, 32'hDEADBEEF, 6'h0C, WK}             // R7 bad -> wake
  };

  logic        clk, rst_n, wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        osc_en, osc_pause, phase_en, phase_flip, bad_write;
  logic [1:0]  range_sel;
  logic [7:0]  stage_mask, phase_shift;
  logic [23:0] drive;
  logic [4:0]  div_code;
  logic [5:0]  div_ratio;
  int n_chk = 0;
  int n_fail = 0;

  osc_keyreg_bank i_osc_keyreg_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .osc_en_o(osc_en), .osc_pause_o(osc_pause), .range_o(range_sel),
    .stage_mask_o(stage_mask), .drive_o(drive), .div_code_o(div_code),
    .div_ratio_o(div_ratio), .phase_en_o(phase_en), .phase_flip_o(phase_flip),
    .phase_shift_o(phase_shift), .bad_write_o(bad_write)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 en", {31'd0, osc_en}, 32'd1);
    chk("R1 pause", {31'd0, osc_pause}, 32'd0);
    chk("R1 mask", {24'd0, stage_mask}, 32'hFF);
    chk("R1 drive", {8'd0, drive}, 32'd0);
    chk("R1 ratio", {26'd0, div_ratio}, 32'd16);
    chk("R1 phase", {22'd0, phase_en, phase_flip, phase_shift}, 32'h200);
    chk("R1 bad", {31'd0, bad_write}, 32'd0);
    rd(6'h00, r); chk("R1 ctrl rd", r, 32'h00FABFA4);
    rd(6'h10, r); chk("R1 div rd", r, 32'h00000AB0);
    rd(6'h18, r); chk("R1 stat rd", r, 32'h00000002);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      wr(v[75:70], v[69:38]);
      rd(v[37:32], r);
      n_chk++;
      if (r !== v[31:0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", v[79:76], i, r, v[31:0]);
      end
    end

    // R3 stage masks per Gray selector
    wr(6'h00, 32'h00FABFA5); chk("R3 medium mask", {24'd0, stage_mask}, 32'h3F);
    wr(6'h00, 32'h00FABFA7); chk("R3 high mask", {24'd0, stage_mask}, 32'h0F);
    wr(6'h00, 32'h00FABFA6); chk("R3 toohigh mask", {24'd0, stage_mask}, 32'h03);
    chk("R3 range out", {30'd0, range_sel}, 32'd2);
    // R2 disable at port, R10 visible next cycle
    wr(6'h00, 32'h00D1EFA4); chk("R2 R10 disabled", {31'd0, osc_en}, 32'd0);
    chk("R3 low mask", {24'd0, stage_mask}, 32'hFF);

    // R4 port packing and word independence
    wr(6'h04, 32'h96967531); chk("R4 stages0-3", {20'd0, drive[11:0]}, 32'h00000F59);
    wr(6'h08, 32'h00000777); chk("R4 stages4-7 cleared", {20'd0, drive[23:12]}, 32'd0);
    chk("R4 word A kept", {20'd0, drive[11:0]}, 32'h00000F59);

    // R5 ratios
    wr(6'h10, 32'h00000AA0); chk("R5 ratio 32", {26'd0, div_ratio}, 32'd32);
    wr(6'h10, 32'h00000AA1); chk("R5 ratio 1", {26'd0, div_ratio}, 32'd1);
    wr(6'h10, 32'h00000123); chk("R5 safe code", {27'd0, div_code}, 32'd31);

    // R6 / R7 at ports
    wr(6'h14, 32'h00FF03AA); chk("R6 ports", {22'd0, phase_en, phase_flip, phase_shift}, 32'h3FF);
    wr(6'h0C, PZ); chk("R7 paused", {31'd0, osc_pause}, 32'd1);
    wr(6'h0C, 32'h00000000); chk("R7 wake", {31'd0, osc_pause}, 32'd0);

    // R8 sticky flag
    wr(6'h18, 32'h00000001); chk("R8 clear", {31'd0, bad_write}, 32'd0);
    wr(6'h10, 32'h00000AA5); chk("R8 valid keeps clear", {31'd0, bad_write}, 32'd0);
    wr(6'h14, 32'h00000001); chk("R8 set", {31'd0, bad_write}, 32'd1);
    wr(6'h10, 32'h00000AA7); chk("R8 valid keeps set", {31'd0, bad_write}, 32'd1);
    wr(6'h18, 32'h00000000); chk("R8 write 0 no effect", {31'd0, bad_write}, 32'd1);
    rd(6'h18, r); chk("R8 status rd", r, 32'h00000001);
    wr(6'h18, 32'hFFFFFFFF); chk("R8 w1c", {31'd0, bad_write}, 32'd0);

    // R9 unmapped reads and writes
    wr(6'h24, 32'hFFFFFFFF); chk("R9 unmapped write", {31'd0, bad_write}, 32'd0);
    rd(6'h1C, r); chk("R9 rd 0x1C", r, 32'd0);
    rd(6'h20, r); chk("R9 rd 0x20", r, 32'd0);
    rd(6'h24, r); chk("R9 rd 0x24", r, 32'd0);
    rd(6'h3C, r); chk("R9 rd 0x3C", r, 32'd0);
    rd(6'h13, r); chk("R9 low addr bits ignored", r, 32'h00000AA7);

    report();
  end
endmodule